// File: doc/BRIEF.md
# Memory Protection Access Checker

This block decides, in the same cycle as the access, whether a bus access may proceed. It holds a global control word, a vector-table size and a set of programmable protection regions. It checks every presented access against these, using the address, the privilege level, the access kind and whether the core is running a hard-fault or NMI handler. When the access is refused it raises a fault strobe. When an enabled region covers the address, it also reports the number of that region.

Software programs the block through a simple synchronous register port, and a read port returns the stored values. A privileged-only background map sits beneath the regions as an implicit lowest-priority entry. Two address windows are always open while protection is on: the system control space (0xE000E000 to 0xE000EFFF) and the vector table (from address 0 up to the programmed size). A dedicated control bit decides whether protection stays active inside the hard-fault and NMI handlers. Wherever the default memory map applies, this block permits every access.

Top module: `mpu_check`

## Requirements
- R1: The control word sits at register address 0. Bit 0 is the global enable, bit 1 keeps protection active in fault handlers, and bit 2 opens the privileged background map. A read of address 0 returns only these three bits, with bits 31:3 reading as zero even after all ones are written.
- R2: While the global enable is 0, no access ever faults, whatever the privilege, kind, address and background bit.
- R3: With the global enable at 1 and control bit 1 at 0, an access presented with acc_hfnmi=1 never faults. With control bit 1 at 1, such an access is checked like any other.
- R4: Region i has a base word at register address 2+2i (bits 31:8 hold the base) and an attribute word at 3+2i. In the attribute word, bit 0 is the enable, bits 5:1 hold a size code k (values below 7 act as 7) giving 2^(k+1) bytes, bits 10:8 hold the permission code and bit 12 is execute-never. The region covers base to base+2^(k+1)-1. acc_hit is 1 and acc_region names the highest-numbered enabled region that covers the address. Disabled regions never match.
- R5: The permission code of the matching region grants rights as follows, written as privileged/unprivileged: 0 none/none, 1 RW/none, 2 RW/RO, 3 RW/RW, 4 none/none, 5 RO/none, 6 RO/RO, 7 RO/RO. acc_kind 0 is a read and needs read right. acc_kind 1 is a write and needs write right. A missing right raises a fault.
- R6: A fetch (acc_kind 2) needs read right in the matching region and faults when that region has execute-never set.
- R7: With protection active and the background bit at 1, an access that matches no enabled region is permitted when privileged and faults when unprivileged.
- R8: With protection active and the background bit at 0, an access that matches no enabled region faults at either privilege.
- R9: With protection active, any access to 0xE000E000 through 0xE000EFFF is permitted.
- R10: Register address 1 holds the vector-table size in bytes. With protection active, an access to an address below that size is permitted.
- R11: acc_fault is combinational from the access inputs and the stored state in the same cycle, and it is 0 whenever acc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | 1 = privileged software |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_hfnmi | input | 1 | Core is in a hard-fault or NMI handler |
| acc_fault | output | 1 | Access refused this cycle |
| acc_hit | output | 1 | An enabled region covers the address |
| acc_region | output | 3 | Number of the winning region |

## Verification
A register write takes effect at the next rising edge. The access decision and the read data are combinational, so they are due in the same cycle the inputs are driven. The bench writes registers at the falling edge and lets one rising edge pass. It then drives each access at a falling edge and samples the outputs 1 ns later, well before the next rising edge. Each sample is compared with a model built from the region table in the bench, which sweeps every control value, privilege, kind and handler state over a set of boundary addresses.

// File: rtl/mpu_check.sv
module mpu_check #(
  parameter int NREG = 8,
  parameter logic [31:0] SCS_LO = 32'hE000_E000,
  parameter logic [31:0] SCS_HI = 32'hE000_EFFF,
  localparam int RIW = $clog2(NREG),
  localparam int CAW = $clog2(2 * NREG + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            acc_valid,
  input  logic [31:0]     acc_addr,
  input  logic            acc_priv,
  input  logic [1:0]      acc_kind,
  input  logic            acc_hfnmi,
  output logic            acc_fault,
  output logic            acc_hit,
  output logic [RIW-1:0]  acc_region
);

  logic [2:0]  ctrl;
  logic [31:0] vt_size;
  logic [23:0] rbase [NREG];
  logic [12:0] rattr [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      vt_size <= '0;
      for (int i = 0; i < NREG; i++) begin
        rbase[i] <= '0;
        rattr[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == 0) ctrl <= cfg_wdata[2:0];
      else if (cfg_addr == 1) vt_size <= cfg_wdata;
      else begin
        for (int i = 0; i < NREG; i++) begin
          if (int'(cfg_addr) == 2 + 2 * i) rbase[i] <= cfg_wdata[31:8];
          if (int'(cfg_addr) == 3 + 2 * i) rattr[i] <= cfg_wdata[12:0];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == 0) cfg_rdata = {29'd0, ctrl};
    else if (cfg_addr == 1) cfg_rdata = vt_size;
    else
      for (int i = 0; i < NREG; i++) begin
        if (int'(cfg_addr) == 2 + 2 * i) cfg_rdata = {rbase[i], 8'h00};
        if (int'(cfg_addr) == 3 + 2 * i) cfg_rdata = {19'd0, rattr[i]};
      end
  end

  logic [NREG-1:0] match;
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      logic [5:0] sh;
      sh = (rattr[i][5:1] < 5'd7) ? 6'd8 : {1'b0, rattr[i][5:1]} + 6'd1;
      match[i] = rattr[i][0] && (((acc_addr ^ {rbase[i], 8'h00}) >> sh) == 32'd0);
    end
  end

  always_comb begin
    acc_hit = 1'b0;
    acc_region = '0;
    for (int i = 0; i < NREG; i++)
      if (match[i]) begin
        acc_hit = 1'b1;
        acc_region = RIW'(i);
      end
  end

  wire [2:0] ap = rattr[acc_region][10:8];
  wire       xn = rattr[acc_region][12];
  wire rd_ok = acc_priv ? (ap != 3'd0 && ap != 3'd4)
                        : (ap == 3'd2 || ap == 3'd3 || ap == 3'd6 || ap == 3'd7);
  wire wr_ok = acc_priv ? (ap == 3'd1 || ap == 3'd2 || ap == 3'd3) : (ap == 3'd3);
  wire reg_ok = (acc_kind == 2'd1) ? wr_ok : (acc_kind == 2'd2) ? (rd_ok && !xn) : rd_ok;

  wire active  = ctrl[0] && !(acc_hfnmi && !ctrl[1]);
  wire in_scs  = acc_addr >= SCS_LO && acc_addr <= SCS_HI;
  wire in_vt   = acc_addr < vt_size;
  wire allowed = !active || in_scs || in_vt ||
                 (acc_hit ? reg_ok : (ctrl[2] && acc_priv));

  assign acc_fault = acc_valid && !allowed;

  a_r11_fault_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> acc_valid);
  a_r2_off_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !acc_fault);
  a_r3_handler_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hfnmi && !ctrl[1]) |-> !acc_fault);
  a_r9_scs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= SCS_LO && acc_addr <= SCS_HI) |-> !acc_fault);
  a_r1_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 0) |-> (cfg_rdata[31:3] == 29'd0));
  a_r4_hit_is_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> rattr[acc_region][0]);
  a_r1_ctrl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 0) |=> (ctrl == $past(cfg_wdata[2:0])));

endmodule

// File: tb/mpu_check_bench.sv
module mpu_check_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic acc_valid = 0, acc_priv = 0, acc_hfnmi = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0] acc_kind = 0;
  logic acc_fault, acc_hit;
  logic [2:0] acc_region;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] m_base [8];
  int m_k [8];
  bit m_en [8], m_xn [8];
  int m_ap [8];
  logic [31:0] m_vt = 0;

  always #2 clk = ~clk;

  mpu_check u_mpu_check (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .acc_valid, .acc_addr, .acc_priv, .acc_kind, .acc_hfnmi,
    .acc_fault, .acc_hit, .acc_region);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_region(int i, logic [31:0] b, int k, bit en, int ap, bit xn);
    m_base[i] = b; m_k[i] = k; m_en[i] = en; m_ap[i] = ap; m_xn[i] = xn;
    wr(5'(2 + 2 * i), b);
    wr(5'(3 + 2 * i), {19'd0, xn, 1'b0, 3'(ap), 2'b00, 5'(k), en});
  endtask

  function automatic bit can(int ap, bit p, bit w);
    case (ap)
      1: return p;
      2: return p || !w;
      3: return 1;
      5: return p && !w;
      6, 7: return !w;
      default: return 0;
    endcase
  endfunction

  task automatic sweep(logic [2:0] c, ref logic [31:0] addrs [$]);
    foreach (addrs[n])
      for (int p = 0; p < 2; p++)
        for (int kd = 0; kd < 3; kd++)
          for (int hf = 0; hf < 2; hf++) begin
            bit h = 0, ok, act;
            int ri = 0;
            string tag;
            logic [31:0] a = addrs[n];
            for (int r = 0; r < 8; r++) begin
              longint unsigned sz = 64'd1 << ((m_k[r] < 7 ? 7 : m_k[r]) + 1);
              if (m_en[r] && a >= m_base[r] && 64'(a) < 64'(m_base[r]) + sz) begin
                h = 1; ri = r;
              end
            end
            act = c[0] && !(hf == 1 && !c[1]);
            if (!c[0]) begin tag = "R2"; ok = 1; end
            else if (!act) begin tag = "R3"; ok = 1; end
            else if (a >= 32'hE000E000 && a <= 32'hE000EFFF) begin tag = "R9"; ok = 1; end
            else if (a < m_vt) begin tag = "R10"; ok = 1; end
            else if (h && kd == 2) begin tag = "R6"; ok = can(m_ap[ri], p == 1, 0) && !m_xn[ri]; end
            else if (h) begin tag = "R5"; ok = can(m_ap[ri], p == 1, kd == 1); end
            else if (c[2]) begin tag = "R7"; ok = (p == 1); end
            else begin tag = "R8"; ok = 0; end
            @(negedge clk);
            acc_valid = 1; acc_addr = a; acc_priv = p[0]; acc_kind = 2'(kd); acc_hfnmi = hf[0];
            #1;
            chk(tag, acc_fault, !ok);
            chk("R4 hit", acc_hit, h);
            if (h) chk("R4 region", acc_region, ri);
          end
  endtask

  initial begin
    logic [31:0] addrs [$];
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_k[i] = 0; m_en[i] = 0; m_ap[i] = 0; m_xn[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); cfg_addr = 0; acc_valid = 1; acc_addr = 32'h3000_0000; #1;
    chk("R1 reset ctrl", cfg_rdata, 0);
    chk("R2 reset open", acc_fault, 0);
    chk("R4 reset nohit", acc_hit, 0);
    wr(0, 32'hFFFF_FFFF); cfg_addr = 0; #1;
    chk("R1 reserved zero", cfg_rdata, 32'h7);
    wr(0, 32'h0000_0005); cfg_addr = 0; #1;
    chk("R1 readback", cfg_rdata, 32'h5);
    wr(1, 32'h100); m_vt = 32'h100; cfg_addr = 1; #1;
    chk("R10 vt readback", cfg_rdata, 32'h100);
    set_region(0, 32'h2000_0000, 15, 1, 3, 0);
    set_region(1, 32'h2000_0000, 3, 1, 6, 0);
    set_region(2, 32'h0800_0000, 19, 1, 5, 0);
    set_region(3, 32'h4000_0000, 11, 1, 1, 1);
    set_region(4, 32'h6000_0000, 12, 0, 3, 0);
    set_region(5, 32'h8000_0000, 12, 1, 2, 0);
    set_region(6, 32'h9000_0000, 8, 1, 0, 0);
    set_region(7, 32'hA000_0000, 9, 1, 7, 1);
    cfg_addr = 5'd9; #1;
    chk("R4 attr readback", cfg_rdata, {19'd0, 1'b1, 1'b0, 3'd1, 2'b00, 5'd11, 1'b1});
    @(negedge clk); acc_valid = 0; acc_addr = 32'h3000_0000; acc_priv = 0; acc_hfnmi = 0; #1;
    chk("R11 invalid quiet", acc_fault, 0);
    acc_valid = 1; #1;
    chk("R11 same cycle", acc_fault, 1);
    addrs = '{32'h0000_0010, 32'h0000_00FF, 32'h0000_0100, 32'h0000_0200,
              32'hE000_DFFF, 32'hE000_E000, 32'hE000_EFFF, 32'hE000_F000,
              32'h2000_0000, 32'h2000_00FF, 32'h2000_0100, 32'h2000_FFFF,
              32'h2001_0000, 32'h0800_0004, 32'h4000_0FFC, 32'h4000_1000,
              32'h6000_0010, 32'h8000_0010, 32'h9000_0010, 32'hA000_0010};
    for (int c = 0; c < 8; c++) begin
      wr(0, 32'(c));
      sweep(3'(c), addrs);
    end
    set_region(4, 32'h0000_0000, 31, 1, 2, 0);
    wr(0, 32'h1);
    sweep(3'd1, addrs);
    acc_valid = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule